// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block collects up to fifteen interrupt lines from devices and combines them into one interrupt request. Each line first passes through a two-flop synchronizer. Each line can be sensed in one of two ways. In level mode, the live synchronized input drives the request. In edge mode, a rising edge sets a sticky status bit, and that bit keeps the request asserted until software clears it.

Software reaches five 32-bit registers through a simple register port. The port has a write strobe, a word index, write data and combinational read data.

- Mode register: one bit per line, selecting level or edge sensing.
- Enable register: one bit per line, plus a global enable bit.
- Status register: the sticky latched events.
- Clear register: write-one-to-clear, one bit per line.
- Raw register: the live, unlatched input levels.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the mode, enable and status registers read 0, and `irq_o` is low.
- R2: The mode register is at word index 0. In bit i (for i from 0 to 14), 0 selects level sensing for source i and 1 selects rising-edge sensing.
- R3: The enable register is at word index 1. Bit i (for i from 0 to 14) enables source i. Bit 15 is the global enable, and no request reaches `irq_o` while it is 0.
- R4: The raw register is at word index 4. Bit i gives the level of `src_i[i]` after a two-flop synchronizer, so an input change appears there after two clock edges. It is not latched.
- R5: The status register is at word index 2. Bit i becomes 1 one clock after the synchronized source i rises, in either sensing mode. It then stays 1 until it is cleared.
- R6: The clear register is at word index 3. Writing 1 to bit i clears status bit i. Writing 0 leaves it unchanged. The clear register reads as 0.
- R7: When a clear of status bit i falls in the same cycle as a new edge on source i, status bit i stays set.
- R8: `irq_o` equals the global enable ANDed with the OR, over all sources, of (enable bit AND active condition). The active condition is the synchronized level for a level-mode source and the status bit for an edge-mode source.
- R9: Bits 31 to 16 of every register read as 0 and ignore writes. Bit 15 of the mode, status, clear and raw registers reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 15 | Device interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A software clear of a status bit and a fresh rising edge on the same source can land on the same clock edge. The bench provokes this with exact timing. It raises the source, waits the two synchronizer edges, and then places the clear write on the edge where the status bit would be set. It also clears a second status bit that sees no edge in that same write. The bench expects the status register to keep only the bit that had the simultaneous edge. A sweep over all fifteen sources, in both sensing modes, checks that the request follows the live level in level mode and holds until it is cleared in edge mode.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int IDX_W   = 3;
  localparam int GLB_BIT = 15;

  typedef enum logic [IDX_W-1:0] {
    REG_MODE   = 3'd0,
    REG_ENABLE = 3'd1,
    REG_STATUS = 3'd2,
    REG_CLEAR  = 3'd3,
    REG_RAW    = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, status_q, rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl_i;
      // a new edge wins over a clear in the same cycle
      status_q <= (status_q & ~clr_i) | rise;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic [NUM_SRC-1:0] mode_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               glb_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_SRC-1:0] mode_q, en_q;
  logic               glb_q;
  reg_idx_e           idx;

  assign idx = reg_idx_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= '0;
      glb_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (idx == REG_MODE) mode_q <= wdata_i[NUM_SRC-1:0];
      if (idx == REG_ENABLE) begin
        en_q  <= wdata_i[NUM_SRC-1:0];
        glb_q <= wdata_i[GLB_BIT];
      end
    end
  end

  assign clr_o = (wr_en_i && idx == REG_CLEAR) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (idx)
      REG_MODE:   rdata_o[NUM_SRC-1:0] = mode_q;
      REG_ENABLE: begin
        rdata_o[NUM_SRC-1:0] = en_q;
        rdata_o[GLB_BIT]     = glb_q;
      end
      REG_STATUS: rdata_o[NUM_SRC-1:0] = status_i;
      REG_RAW:    rdata_o[NUM_SRC-1:0] = raw_i;
      default:    rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign glb_o  = glb_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] raw, status, mode, en, clr, active;
  logic               glb;

  irq_sync #(.W(NUM_SRC)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i), .q_o(raw)
  );

  irq_edge_latch #(.W(NUM_SRC)) latch_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(raw), .clr_i(clr), .status_o(status)
  );

  irq_regfile #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .status_i(status), .raw_i(raw), .mode_o(mode),
    .en_o(en), .glb_o(glb), .clr_o(clr), .rdata_o(rdata_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_act
    assign active[g] = en[g] & (mode[g] ? status[g] : raw[g]);
  end

  assign irq_o = glb & (|active);
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int NUM_SRC = 15,
  parameter int DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [2:0]         addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] mode,
  input logic [NUM_SRC-1:0] en,
  input logic               glb,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] raw
);
  logic [NUM_SRC-1:0] clr_mask;
  assign clr_mask = (wr_en_i && addr_i == 3'd3) ? wdata_i[NUM_SRC-1:0] : '0;

  // R3
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb |-> !irq_o);

  // R8
  level_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb && |(~mode & en & raw)) |-> irq_o);

  // R8
  edge_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb && |(mode & en & status)) |-> irq_o);

  // R5
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status) |=> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));

  // R9
  resv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:16] == '0);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .mode(mode),
  .en(en), .glb(glb), .status(status), .raw(raw)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 15;
  localparam logic [31:0] MASK = 32'h0000_7FFF;
  localparam logic [31:0] GLB  = 32'h0000_8000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_status_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = idx; wdata_i = d;
    tick(1);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    addr_i = idx;
    #1;
    d = rdata_o;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd1, v); chk("R1 enable", v, 0);
    rd(3'd2, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R9 reserved and bit-15 handling, R2/R3 readback
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R2 R9 mode readback", v, MASK);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R3 R9 enable readback", v, MASK | GLB);
    wr(3'd1, 32'h0); rd(3'd1, v); chk("R3 enable clear", v, 0);
    wr(3'd0, 32'h0);
    rd(3'd3, v); chk("R6 R9 clear reads 0", v, 0);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R9 unmapped index", v, 0);

    // R4 raw latency and patterns; R5 status latching
    for (int p = 0; p < 6; p++) begin
      pat = (p == 5) ? MASK : ((32'h1 << (p * 3)) | (32'h2 << p)) & MASK;
      src_i = pat[NS-1:0];
      tick(1); rd(3'd4, v); chk("R4 raw after one edge", v, 0);
      tick(1); rd(3'd4, v); chk("R4 raw after two edges", v, pat);
      tick(1); rd(3'd2, v); chk("R5 status latched", v, pat);
      src_i = '0;
      tick(3); rd(3'd4, v); chk("R4 raw follows low", v, 0);
      rd(3'd2, v); chk("R5 status sticky", v, pat);
      wr(3'd3, 32'h0); rd(3'd2, v); chk("R6 write 0 no effect", v, pat);
      wr(3'd3, 32'hFFFF_0000 | (pat & 32'h5555)); rd(3'd2, v);
      chk("R6 partial clear", v, pat & ~32'h5555);
      wr(3'd3, 32'hFFFF_FFFF); rd(3'd2, v); chk("R6 full clear", v, 0);
    end

    // R7 clear and edge in the same cycle
    src_i = 15'h0020; tick(3);
    src_i = '0; tick(3);
    rd(3'd2, v); chk("R7 setup", v, 32'h20);
    src_i = 15'h0008;
    tick(2);
    wr(3'd3, 32'h28);
    rd(3'd2, v); chk("R7 edge beats clear", v, 32'h08);
    src_i = '0; tick(3);
    wr(3'd3, 32'hFFFF);

    // R8 sweep over every source in both modes
    for (int i = 0; i < NS; i++) begin
      for (int m = 0; m < 2; m++) begin
        wr(3'd0, m ? (32'h1 << i) : 32'h0);
        wr(3'd1, (32'h1 << i) | GLB);
        src_i = ~(15'h1 << i); tick(3);
        chk($sformatf("R8 src%0d m%0d others ignored", i, m), {31'd0, irq_o}, 0);
        src_i = 15'h1 << i; tick(2);
        chk($sformatf("R8 src%0d m%0d level timing", i, m), {31'd0, irq_o}, m ? 0 : 1);
        tick(1);
        chk($sformatf("R8 src%0d m%0d asserted", i, m), {31'd0, irq_o}, 1);
        src_i = '0; tick(3);
        chk($sformatf("R8 src%0d m%0d after drop", i, m), {31'd0, irq_o}, m);
        wr(3'd3, 32'h1 << i);
        chk($sformatf("R8 src%0d m%0d after clear", i, m), {31'd0, irq_o}, 0);
        wr(3'd3, 32'hFFFF);
      end
    end

    // R3 global enable gates the request
    wr(3'd0, 32'h0);
    wr(3'd1, MASK);
    src_i = 15'h7FFF; tick(3);
    chk("R3 no global, no irq", {31'd0, irq_o}, 0);
    wr(3'd1, MASK | GLB);
    chk("R3 global on", {31'd0, irq_o}, 1);
    src_i = '0; tick(3);
    wr(3'd3, 32'hFFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule